// File: doc/BRIEF.md
# Progressive Arrow Sign Sequencer

This block is a clocked Moore state machine for a five-lamp arrow sign whose lamps are wired as three drive groups: a leading pair, a middle pair and a single tip lamp. While the run switch is on, each step adds a group, so the sign shows nothing, then the leading pair, then both pairs, then all five lamps, and then goes dark and starts over. When the switch is off, the machine returns to the dark phase on the next step and stays there.

Stepping happens on clock edges on which the step-rate enable is high. A slower strobe on that input sets a visible blink rate without a divider inside the block. The lamp drives are decoded from the 2-bit phase register alone and never from the switch. The phase is also brought out as an output.

Top module: `arrow_sign_seq`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is asserted, the phase is 0 (code 2'b00) and all three lamp drives are 0.
- R2: The phase codes are 0 = dark, 1 = leading pair, 2 = both pairs, 3 = all lamps. On a clock edge with `step_en`=1 and `run`=1, the phase advances 0→1→2→3→0.
- R3: On a clock edge with `step_en`=1 and `run`=0, the next phase is 0, whatever the current phase is.
- R4: On a clock edge with `step_en`=0, the phase does not change, whatever the value of `run`.
- R5: `lamp_pair_a` is 1 exactly when the phase is not 0.
- R6: `lamp_pair_b` is 1 exactly when the phase is 2 or 3, that is when phase bit 1 is set.
- R7: `lamp_tip` is 1 exactly when the phase is 3.
- R8: The lamp outputs depend only on the registered phase. A change on `run` or `step_en` between clock edges does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Step-rate enable; the phase is updated only on edges where it is 1 |
| run | input | 1 | Sign switch; when it is 0, the sign returns to dark |
| lamp_pair_a | output | 1 | Drive for the leading lamp pair |
| lamp_pair_b | output | 1 | Drive for the middle lamp pair |
| lamp_tip | output | 1 | Drive for the tip lamp |
| phase | output | 2 | Current phase code |

## Verification
The bench drives the switch off from each of the four phases. This catches a design that clears only from some phases, or one that wraps back to dark through the normal sequence instead of jumping there. It runs several full cycles with the enable stuck high and checks every lamp on every cycle, so a swapped decode or a skipped phase shows up as a wrong lamp pattern. It holds the enable low while toggling the switch, which exposes a design that clears or advances without the enable. It also toggles the inputs between clock edges, which exposes lamp logic that looks at the inputs directly and is not a true Moore decode.

// File: rtl/arrow_sign_pkg.sv
package arrow_sign_pkg;
  localparam int PHASE_W = 2;
  typedef enum logic [PHASE_W-1:0] {
    PH_DARK = 2'b00,
    PH_LEAD = 2'b01,
    PH_MID  = 2'b10,
    PH_FULL = 2'b11
  } phase_t;
endpackage

// File: rtl/arrow_sign_next.sv
module arrow_sign_next
  import arrow_sign_pkg::*;
(
  input  phase_t cur,
  input  logic   run,
  output phase_t nxt
);
  always_comb begin
    if (!run) begin
      nxt = PH_DARK;
    end else begin
      unique case (cur)
        PH_DARK: nxt = PH_LEAD;
        PH_LEAD: nxt = PH_MID;
        PH_MID:  nxt = PH_FULL;
        default: nxt = PH_DARK;
      endcase
    end
  end
endmodule

// File: rtl/arrow_sign_decode.sv
module arrow_sign_decode
  import arrow_sign_pkg::*;
(
  input  phase_t cur,
  output logic   pair_a,
  output logic   pair_b,
  output logic   tip
);
  always_comb begin
    pair_a = cur[1] | cur[0];
    pair_b = cur[1];
    tip    = cur[1] & cur[0];
  end
endmodule

// File: rtl/arrow_sign_seq.sv
module arrow_sign_seq
  import arrow_sign_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_en,
  input  logic       run,
  output logic       lamp_pair_a,
  output logic       lamp_pair_b,
  output logic       lamp_tip,
  output logic [1:0] phase
);
  phase_t cur_q, nxt_d;

  arrow_sign_next u_next (.cur(cur_q), .run(run), .nxt(nxt_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_q <= PH_DARK;
    else if (step_en) cur_q <= nxt_d;
  end

  arrow_sign_decode u_dec (
    .cur(cur_q), .pair_a(lamp_pair_a), .pair_b(lamp_pair_b), .tip(lamp_tip)
  );

  assign phase = cur_q;

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !run) |=> (phase == 2'b00));
  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && run) |=> (phase == 2'(($past(phase)) + 2'd1)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(phase));
  p_tip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_tip |-> (lamp_pair_a && lamp_pair_b));
  p_pairb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_pair_b |-> lamp_pair_a);
endmodule

// File: tb/tb_arrow_sign_seq.sv
module tb_arrow_sign_seq;
  logic clk = 0, rst_n = 0, step_en = 0, run = 0;
  logic pa, pb, tp;
  logic [1:0] ph;
  int errs = 0, checks = 0;
  logic [1:0] model = 0;

  arrow_sign_seq dut (.clk(clk), .rst_n(rst_n), .step_en(step_en), .run(run),
    .lamp_pair_a(pa), .lamp_pair_b(pb), .lamp_tip(tp), .phase(ph));

  always #5 clk = ~clk;

  task automatic chk(input string req);
    logic ea, eb, et;
    ea = (model != 0); eb = (model >= 2); et = (model == 3);
    checks++;
    if (ph !== model || pa !== ea || pb !== eb || tp !== et) begin
      errs++;
      $display("FAIL %s: got ph=%0d lamps=%b%b%b expected ph=%0d lamps=%b%b%b",
               req, ph, pa, pb, tp, model, ea, eb, et);
    end
  endtask

  task automatic step(input logic en, input logic r, input string req);
    step_en = en; run = r;
    @(posedge clk);
    if (en) model = r ? 2'(model + 1) : 2'd0;
    #2 chk(req);
  endtask

  initial begin
    #1000000;
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #12 chk("R1");
    rst_n = 1;
    for (int i = 0; i < 12; i++) step(1, 1, "R2 R5 R6 R7");
    for (int s = 0; s < 4; s++) begin
      model = 0; rst_n = 0; #3 chk("R1"); rst_n = 1;
      for (int k = 0; k < s; k++) step(1, 1, "R2");
      step(0, 0, "R4");
      step(0, 1, "R4");
      step(1, 0, "R3");
      step(1, 0, "R3");
    end
    for (int k = 0; k < 3; k++) step(1, 1, "R2");
    step_en = 1; run = 0; #1 chk("R8");
    step_en = 0; run = 1; #1 chk("R8");
    step(0, 0, "R4");
    step(1, 1, "R2");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule